// File: doc/BRIEF.md
# Word ALU with Sign, Zero, Overflow and Carry Status

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it receives an operation code, a word taken from the destination register and a word taken from memory. It returns the new register value on a combinational output. A four-bit status register keeps the sign (N), zero (Z), overflow (V) and carry (C) flags. Each operation writes its own subset of these flags and leaves the rest as they were.

The result depends only on the current inputs and the stored carry, which the rotates shift in. The status register takes its new value on a rising clock edge while the enable input is high. Operand fetch, addressing and register storage belong to the surrounding datapath.

Top module: `flagged_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the status register to 0000. The `flags` output bits are N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R2: While `en` is low, the status register keeps its value across clock edges. `result` still follows the inputs.
- R3: Code 0x0 (add): result = reg + mem modulo 2^16. N is the result sign, Z is set on a zero result, V is set on signed overflow, and C is the carry out of bit 15.
- R4: Code 0x1 (subtract): result = reg - mem modulo 2^16, computed as reg + ~mem + 1. C is the carry out of that sum, so C=1 when reg >= mem unsigned (no borrow). V is set on signed overflow. N and Z are as for add.
- R5: Codes 0x2 (AND) and 0x3 (OR) combine reg with mem bit by bit. They update N and Z only; V and C keep their values.
- R6: Codes 0x4 (invert, ~reg) and 0x5 (negate, 0 - reg) update N and Z only.
- R7: Code 0x6 (shift left): result = reg << 1 with a zero fill. C takes the old bit 15. V is set when bit 15 of the result differs from the old bit 15. N and Z are updated.
- R8: Code 0x7 (shift right): result = reg >> 1 with the old bit 15 copied into bit 15. C takes the old bit 0. N and Z are updated; V is kept.
- R9: Codes 0x8 (rotate left) and 0x9 (rotate right) shift through the stored C. Rotate left fills bit 0 with C, and C takes the old bit 15. Rotate right fills bit 15 with C, and C takes the old bit 0. Only C changes.
- R10: Code 0xA (word load): result = mem. N and Z are updated.
- R11: Code 0xB (byte load): result = {reg[15:8], mem[7:0]}. N and Z are taken from the full 16-bit result; V and C are kept.
- R12: Code 0xC (store) and the unused codes 0xD to 0xF give result = reg and leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the status register |
| en | input | 1 | Status register update enable |
| op_sel | input | 4 | Operation code |
| reg_opnd | input | 16 | Register operand |
| mem_opnd | input | 16 | Memory operand |
| result | output | 16 | Combinational result |
| flags | output | 4 | Status register {N,Z,V,C} |

## Verification
The hardest case to reach is a flag that an operation must leave untouched while it holds an unexpected value, for example a V or C set long ago that a later logic operation or rotate must preserve. To reach it, the stimulus first runs overflowing additions and borrowing subtractions, which put V and C in known non-zero states. It then applies partial-update operations and toggles the enable. A long randomized phase mixes all sixteen codes, so that rotates consume carries left by every kind of earlier operation. The behavioural model checks each of these outcomes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_AND  = 4'h2,
        OP_OR   = 4'h3,
        OP_NOT  = 4'h4,
        OP_NEG  = 4'h5,
        OP_ASL  = 4'h6,
        OP_ASR  = 4'h7,
        OP_ROL  = 4'h8,
        OP_ROR  = 4'h9,
        OP_LDW  = 4'hA,
        OP_LDB  = 4'hB,
        OP_STW  = 4'hC,
        OP_RSVD = 4'hD,
        OP_RSVE = 4'hE,
        OP_RSVF = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    typedef enum logic [1:0] {
        UNIT_ARITH,
        UNIT_SHIFT,
        UNIT_BITWISE
    } unit_sel_e;

    // Which flags an operation is allowed to overwrite.
    function automatic nzvc_t flag_mask(input alu_op_e op);
        nzvc_t m;
        m = '0;
        case (op)
            OP_ADD, OP_SUB, OP_ASL:            m = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
            OP_ASR:                            m = '{n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b1};
            OP_AND, OP_OR, OP_NOT, OP_NEG,
            OP_LDW, OP_LDB:                    m = '{n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b0};
            OP_ROL, OP_ROR:                    m = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b1};
            default:                           m = '0;
        endcase
        return m;
    endfunction

    function automatic unit_sel_e unit_of(input alu_op_e op);
        unit_sel_e u;
        case (op)
            OP_ADD, OP_SUB:                    u = UNIT_ARITH;
            OP_ASL, OP_ASR, OP_ROL, OP_ROR:    u = UNIT_SHIFT;
            default:                           u = UNIT_BITWISE;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[WIDTH-1:0];
        cout  = wide[WIDTH];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);
    localparam int HALF = WIDTH / 2;

    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_NOT:  res = ~a;
            OP_NEG:  res = (~a) + {{(WIDTH-1){1'b0}}, 1'b1};
            OP_LDW:  res = b;
            OP_LDB:  res = {a[WIDTH-1:HALF], b[HALF-1:0]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             ovf,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    logic             fill_lo;
    logic             fill_hi;
    logic             go_left;
    logic [WIDTH-1:0] up;
    logic [WIDTH-1:0] down;

    assign fill_lo = (op == OP_ROL) ? cin : 1'b0;
    assign fill_hi = (op == OP_ASR) ? a[MSB] : cin;
    assign go_left = (op == OP_ASL) || (op == OP_ROL);

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        if (i == 0) begin : g_lo
            assign up[i] = fill_lo;
        end else begin : g_mid_up
            assign up[i] = a[i-1];
        end
        if (i == MSB) begin : g_hi
            assign down[i] = fill_hi;
        end else begin : g_mid_down
            assign down[i] = a[i+1];
        end
    end

    always_comb begin
        res  = go_left ? up : down;
        cout = go_left ? a[MSB] : a[0];
        ovf  = a[MSB] ^ a[MSB-1];
    end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] res,
    input  logic             unit_v,
    input  logic             unit_c,
    input  nzvc_t            cur,
    output nzvc_t            nxt
);
    nzvc_t mask;
    nzvc_t fresh;

    always_comb begin
        mask    = flag_mask(op);
        fresh.n = res[WIDTH-1];
        fresh.z = ~|res;
        fresh.v = unit_v;
        fresh.c = unit_c;
        nxt     = nzvc_t'((fresh & mask) | (cur & ~mask));
    end
endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] reg_opnd,
    input  logic [WIDTH-1:0] mem_opnd,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags
);
    localparam int HALF = WIDTH / 2;

    alu_op_e          op;
    nzvc_t            status;
    nzvc_t            status_nxt;
    logic [WIDTH-1:0] arith_res, shift_res, bit_res;
    logic             arith_v, arith_c, shift_v, shift_c;
    logic             unit_v, unit_c;

    assign op = alu_op_e'(op_sel);

    alu_addsub #(.WIDTH(WIDTH)) u_arith (
        .a    (reg_opnd),
        .b    (mem_opnd),
        .sub  (op == OP_SUB),
        .sum  (arith_res),
        .ovf  (arith_v),
        .cout (arith_c)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .op   (op),
        .a    (reg_opnd),
        .cin  (status.c),
        .res  (shift_res),
        .ovf  (shift_v),
        .cout (shift_c)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bits (
        .op  (op),
        .a   (reg_opnd),
        .b   (mem_opnd),
        .res (bit_res)
    );

    always_comb begin
        case (unit_of(op))
            UNIT_ARITH: begin
                result = arith_res;
                unit_v = arith_v;
                unit_c = arith_c;
            end
            UNIT_SHIFT: begin
                result = shift_res;
                unit_v = shift_v;
                unit_c = shift_c;
            end
            default: begin
                result = bit_res;
                unit_v = 1'b0;
                unit_c = 1'b0;
            end
        endcase
    end

    alu_flag_merge #(.WIDTH(WIDTH)) u_merge (
        .op     (op),
        .res    (result),
        .unit_v (unit_v),
        .unit_c (unit_c),
        .cur    (status),
        .nxt    (status_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (en) begin
            status <= status_nxt;
        end
    end

    assign flags = status;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (flags == 4'b0000)) else $error("reset did not clear flags"); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(flags)) else $error("flags moved while disabled"); // R2
    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == 4'h1) |=> (flags[0] == $past(reg_opnd >= mem_opnd))) else $error("subtract carry wrong"); // R4
    AST_LOGIC_KEEPS_VC: assert property (@(posedge clk) disable iff (rst)
        (en && (op_sel == 4'h2 || op_sel == 4'h3 || op_sel == 4'h4 || op_sel == 4'h5))
        |=> (flags[1:0] == $past(flags[1:0]))) else $error("logic op touched V or C"); // R5
    AST_ROTATE_ONLY_C: assert property (@(posedge clk) disable iff (rst)
        (en && (op_sel == 4'h8 || op_sel == 4'h9)) |=> (flags[3:1] == $past(flags[3:1]))) else $error("rotate touched N, Z or V"); // R9
    AST_BYTE_LOAD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'hB) |-> (result[WIDTH-1:HALF] == reg_opnd[WIDTH-1:HALF])) else $error("byte load changed high half"); // R11
    AST_STORE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel >= 4'hC) |=> $stable(flags)) else $error("store changed flags"); // R12
    AST_STORE_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 4'hC) |-> (result == reg_opnd)) else $error("store result wrong"); // R12
endmodule

// File: tb/flagged_alu_test.sv
`timescale 1ns/1ps
module flagged_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [3:0]  op_sel = 4'h0;
    logic [15:0] reg_opnd = 16'h0;
    logic [15:0] mem_opnd = 16'h0;
    logic [15:0] result;
    logic [3:0]  flags;

    int checks = 0;
    int failures = 0;
    int model_flags = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flagged_alu uut (
        .clk(clk), .rst(rst), .en(en), .op_sel(op_sel),
        .reg_opnd(reg_opnd), .mem_opnd(mem_opnd),
        .result(result), .flags(flags)
    );

    function automatic int to_signed16(input int x);
        return (x >= 32768) ? x - 65536 : x;
    endfunction

    // Behavioural reference: flags as integer 8=N 4=Z 2=V 1=C.
    function automatic void model(input int op, input int a, input int b, input int f,
                                  output int res, output int nf);
        int n, z, v, c, t, s;
        bit wn, wz, wv, wc;
        n = (f / 8) % 2; z = (f / 4) % 2; v = (f / 2) % 2; c = f % 2;
        wn = 0; wz = 0; wv = 0; wc = 0;
        res = a;
        case (op)
            0: begin t = a + b; res = t % 65536; s = to_signed16(a) + to_signed16(b);
                   v = (s > 32767 || s < -32768); c = (t > 65535); wn = 1; wz = 1; wv = 1; wc = 1; end
            1: begin res = (a - b + 65536) % 65536; s = to_signed16(a) - to_signed16(b);
                   v = (s > 32767 || s < -32768); c = (a >= b); wn = 1; wz = 1; wv = 1; wc = 1; end
            2: begin res = a & b; wn = 1; wz = 1; end
            3: begin res = a | b; wn = 1; wz = 1; end
            4: begin res = 65535 - a; wn = 1; wz = 1; end
            5: begin res = (65536 - a) % 65536; wn = 1; wz = 1; end
            6: begin res = (a * 2) % 65536; c = (a >= 32768); v = ((a >= 32768) != (res >= 32768));
                   wn = 1; wz = 1; wv = 1; wc = 1; end
            7: begin res = a / 2 + ((a >= 32768) ? 32768 : 0); c = a % 2; wn = 1; wz = 1; wc = 1; end
            8: begin res = (a * 2) % 65536 + (f % 2); c = (a >= 32768); wc = 1; end
            9: begin res = a / 2 + (f % 2) * 32768; c = a % 2; wc = 1; end
            10: begin res = b; wn = 1; wz = 1; end
            11: begin res = (a / 256) * 256 + b % 256; wn = 1; wz = 1; end
            default: res = a;
        endcase
        if (wn) n = (res >= 32768);
        if (wz) z = (res == 0);
        nf = f;
        if (wn || wz || wv || wc) nf = n * 8 + z * 4 + v * 2 + c;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2, 3: return "R5";
            4, 5: return "R6";
            6: return "R7";
            7: return "R8";
            8, 9: return "R9";
            10: return "R10";
            11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input int op, input int a, input int b, input bit e, input bit r, input string req);
        int eres, enf;
        @(negedge clk);
        op_sel = op[3:0]; reg_opnd = a[15:0]; mem_opnd = b[15:0]; en = e; rst = r;
        #1;
        model(op, a, b, model_flags, eres, enf);
        if (!r) check(req, "result", int'(result), eres);
        @(posedge clk);
        #1;
        if (r) model_flags = 0;
        else if (e) model_flags = enf;
        check(r ? "R1" : (e ? req : "R2"), "flags", int'(flags), model_flags);
    endtask

    initial begin
        step(0, 0, 0, 1, 1, "R1");
        step(0, 16'hFFF9, 16'h0005, 1, 0, "R3");
        step(0, 16'h7FFF, 16'h0001, 1, 0, "R3");
        step(2, 16'h5DC3, 16'h00FF, 1, 0, "R5");
        step(3, 16'h5DC3, 16'h00FF, 1, 0, "R5");
        step(0, 16'hFFFF, 16'h0001, 1, 0, "R3");
        step(4, 16'h0003, 0, 1, 0, "R6");
        step(5, 16'h0003, 0, 1, 0, "R6");
        step(1, 16'h0003, 16'h0009, 1, 0, "R4");
        step(1, 16'h1234, 16'h1234, 1, 0, "R4");
        step(1, 16'h8000, 16'h0001, 1, 0, "R4");
        step(6, 16'h4000, 0, 1, 0, "R7");
        step(6, 16'h8001, 0, 1, 0, "R7");
        step(7, 16'h8001, 0, 1, 0, "R8");
        step(8, 16'h8000, 0, 1, 0, "R9");
        step(8, 16'h0001, 0, 1, 0, "R9");
        step(9, 16'h0001, 0, 1, 0, "R9");
        step(9, 16'h0000, 0, 1, 0, "R9");
        step(10, 16'hAAAA, 16'h0000, 1, 0, "R10");
        step(11, 16'h12AB, 16'hFFCD, 1, 0, "R11");
        step(11, 16'h0012, 16'h3400, 1, 0, "R11");
        step(0, 16'h7FFF, 16'h7FFF, 1, 0, "R3");
        step(12, 16'h0000, 16'h5555, 1, 0, "R12");
        step(14, 16'h8000, 16'h0000, 1, 0, "R12");
        step(15, 16'h0000, 16'h0000, 1, 0, "R12");
        step(0, 16'h0000, 16'h0000, 0, 0, "R2");
        step(1, 16'h0000, 16'h0001, 0, 0, "R2");
        step(0, 0, 0, 1, 1, "R1");
        for (int i = 0; i < 3000; i++) begin
            int op, a, b;
            bit e, r;
            op = int'($urandom_range(0, 15));
            a = int'($urandom_range(0, 65535));
            b = int'($urandom_range(0, 65535));
            if (i % 7 == 0) a = 16'h8000;
            if (i % 11 == 0) b = a;
            e = ($urandom_range(0, 5) != 0);
            r = ($urandom_range(0, 200) == 0);
            step(op, a, b, e, r, tag_of(op));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule